// File: doc/BRIEF.md
# ATA Device Interrupt Request Controller

This block sits on the device side of a parallel ATA link and produces the interrupt request line to the host. The command engine pulses a raise request when a command phase ends, and the block then holds one pending interrupt bit. Several host and reset events clear that bit:

- the active-low host reset,
- a soft reset written through the control register,
- a command register write,
- a status register read,
- the end of a sector data transfer.

Register decoding happens elsewhere. This block only receives one-cycle strobes for these events.

The pin driver places the pending bit on the line only while this device is the selected one and interrupts are enabled. In every other case the line floats. The output enable and the driven value are separate ports, so a pad cell or a bench can model the high-impedance state directly. The pending bit survives while the line floats and shows up again once the device is reselected and enabled.

Top module: `ata_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the pending bit clears, so `irq_val` is 0 after that edge.
- R2: A `raise` pulse with no reset-class event sets the pending bit at the next rising edge.
- R3: `host_rst_n` sampled low clears the pending bit at that edge, even when `raise` is high in the same cycle.
- R4: A `soft_rst` pulse clears the pending bit at that edge, even when `raise` is high in the same cycle.
- R5: A `cmd_wr` pulse without `raise` clears the pending bit.
- R6: A `stat_rd` pulse without `raise` clears the pending bit.
- R7: An `xfer_done` pulse without `raise` clears the pending bit.
- R8: When `raise` coincides with `cmd_wr`, `stat_rd` or `xfer_done`, the pending bit is set.
- R9: `irq_oe` equals `dev_sel AND irq_en` in the same cycle. Whenever `irq_oe` is 0, `irq_val` is 0.
- R10: The pending bit is kept while the line floats. Once `dev_sel` and `irq_en` are both high again, `irq_val` shows it.
- R11: In a cycle with no strobe and `host_rst_n` high, the pending bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| host_rst_n | input | 1 | Host hardware reset, active low |
| soft_rst | input | 1 | Soft reset strobe from the control register |
| cmd_wr | input | 1 | Command register write strobe |
| stat_rd | input | 1 | Status register read strobe |
| xfer_done | input | 1 | Sector data transfer complete strobe |
| raise | input | 1 | Request to set the pending interrupt |
| dev_sel | input | 1 | This device is currently selected |
| irq_en | input | 1 | Interrupts are enabled |
| irq_oe | output | 1 | Line driver enable; 0 means high impedance |
| irq_val | output | 1 | Value driven on the line while enabled |

## Verification
A raise request and a clearing strobe can land in the same cycle, and the outcome depends on which kind of clear it is. The bench fires `raise` together with each host clear (command write, status read, transfer end), where the bit must come out set. It also fires `raise` together with the host reset and the soft reset, where the bit must come out clear. A scoreboard compares each case one edge later against a reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef struct packed {
        logic host_rst_n;
        logic soft_rst;
        logic cmd_wr;
        logic stat_rd;
        logic xfer_done;
        logic raise;
    } irq_evt_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } irq_act_t;

    // Reset-class clears beat raise; raise beats host-access clears.
    function automatic irq_act_t resolve_act(input irq_evt_t e);
        irq_act_t a;
        if (!e.host_rst_n || e.soft_rst)
            a = ACT_CLEAR;
        else if (e.raise)
            a = ACT_SET;
        else if (e.cmd_wr || e.stat_rd || e.xfer_done)
            a = ACT_CLEAR;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge
    import irq_pkg::*;
(
    input  irq_evt_t evt,
    output irq_act_t act
);
    always_comb act = resolve_act(evt);
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_act_t act,
    input  irq_evt_t evt,
    output logic     pending
);
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else begin
            unique case (act)
                ACT_SET:   pending <= 1'b1;
                ACT_CLEAR: pending <= 1'b0;
                default:   pending <= pending;
            endcase
        end
    end

    AST_HRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !evt.host_rst_n |=> !pending); // R3
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.soft_rst |=> !pending); // R4
    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt.raise && evt.host_rst_n && !evt.soft_rst) |=> pending); // R2 R8
    AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((evt.cmd_wr || evt.stat_rd || evt.xfer_done) && !evt.raise) |=> !pending); // R5 R6 R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt.host_rst_n && !evt.soft_rst && !evt.cmd_wr && !evt.stat_rd
         && !evt.xfer_done && !evt.raise) |=> $stable(pending)); // R11
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic dev_sel,
    input  logic irq_en,
    output logic irq_oe,
    output logic irq_val
);
    always_comb begin
        irq_oe  = dev_sel & irq_en;
        irq_val = irq_oe & pending;
    end

    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !irq_oe |-> !irq_val); // R9
    AST_SHOW_PENDING: assert property (@(posedge clk) disable iff (rst)
        (dev_sel && irq_en) |-> (irq_val == pending)); // R10
endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic host_rst_n,
    input  logic soft_rst,
    input  logic cmd_wr,
    input  logic stat_rd,
    input  logic xfer_done,
    input  logic raise,
    input  logic dev_sel,
    input  logic irq_en,
    output logic irq_oe,
    output logic irq_val
);
    irq_evt_t evt;
    irq_act_t act;
    logic     pending;

    always_comb begin
        evt.host_rst_n = host_rst_n;
        evt.soft_rst   = soft_rst;
        evt.cmd_wr     = cmd_wr;
        evt.stat_rd    = stat_rd;
        evt.xfer_done  = xfer_done;
        evt.raise      = raise;
    end

    irq_event_merge u_merge (
        .evt (evt),
        .act (act)
    );

    irq_pending_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .evt     (evt),
        .pending (pending)
    );

    irq_pin_drive u_pin (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .dev_sel (dev_sel),
        .irq_en  (irq_en),
        .irq_oe  (irq_oe),
        .irq_val (irq_val)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !pending); // R1
endmodule

// File: tb/sim_ata_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ata_irq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_rst_n = 1'b1;
    logic soft_rst = 1'b0, cmd_wr = 1'b0, stat_rd = 1'b0, xfer_done = 1'b0, raise = 1'b0;
    logic dev_sel = 1'b0, irq_en = 1'b0;
    logic irq_oe, irq_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_pend = 1'b0;

    typedef struct {
        logic  oe;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    ata_irq_ctrl u0 (
        .clk(clk), .rst(rst), .host_rst_n(host_rst_n), .soft_rst(soft_rst),
        .cmd_wr(cmd_wr), .stat_rd(stat_rd), .xfer_done(xfer_done), .raise(raise),
        .dev_sel(dev_sel), .irq_en(irq_en), .irq_oe(irq_oe), .irq_val(irq_val)
    );

    // Driver: set inputs on a falling edge, predict the state after the next rising edge.
    task automatic step(input bit r, input bit hn, input bit sr, input bit cw,
                        input bit sd, input bit xd, input bit ra,
                        input bit sel, input bit en, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; host_rst_n = hn; soft_rst = sr; cmd_wr = cw;
        stat_rd = sd; xfer_done = xd; raise = ra; dev_sel = sel; irq_en = en;
        if (r || !hn || sr)        model_pend = 1'b0;
        else if (ra)               model_pend = 1'b1;
        else if (cw || sd || xd)   model_pend = 1'b0;
        e.oe  = sel & en;
        e.val = sel & en & model_pend;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one item per rising edge, sampled 1 ns after it.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_oe !== e.oe || irq_val !== e.val) begin
                errors++;
                $display("FAIL %s: oe/val actual %b/%b expected %b/%b",
                         e.tag, irq_oe, irq_val, e.oe, e.val);
            end
        end
    end

    initial begin
        //    rst hn sr cw sd xd ra sel en
        step(1, 1, 0, 0, 0, 0, 0, 1, 1, "R1 reset state");
        step(1, 1, 0, 0, 0, 0, 1, 1, 1, "R1 reset beats raise");
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 raise sets");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R11 idle holds set");
        step(0, 1, 0, 1, 0, 0, 0, 1, 1, "R5 command write clears");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R11 idle holds clear");
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 raise again");
        step(0, 1, 0, 0, 1, 0, 0, 1, 1, "R6 status read clears");
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 raise again");
        step(0, 1, 0, 0, 0, 1, 0, 1, 1, "R7 transfer end clears");
        step(0, 1, 0, 1, 0, 0, 1, 1, 1, "R8 raise with command write");
        step(0, 1, 0, 0, 1, 0, 1, 1, 1, "R8 raise with status read");
        step(0, 1, 0, 0, 0, 1, 1, 1, 1, "R8 raise with transfer end");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, "R3 host reset beats raise");
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 raise after host reset");
        step(0, 1, 1, 0, 0, 0, 1, 1, 1, "R4 soft reset beats raise");
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 raise before float");
        step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R9 not selected floats");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, "R9 disabled floats");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 both off floats");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R10 pending reappears");
        step(0, 1, 0, 0, 1, 0, 0, 0, 1, "R6 status read while floating");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R10 cleared stays clear");
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, "R10 raise while floating");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R10 raised bit shows");
        step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R11 idle final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule